// File: doc/BRIEF.md
# Keystream Generator Frame Sequencer

This block drives a majority-clocked, three-register keystream generator through one complete frame set-up and collects the keystream it produces. A single-cycle `start` presents a 64-bit session key and a 22-bit frame number. The sequencer registers both and then steps the generator through a fixed schedule. The generator is reached only through a 3-bit control word and returns one keystream bit per clock. The schedule is: clear the generator, load the key and then the frame number serially with every register forced to shift, run a mixing period whose output is thrown away, and capture two 114-bit keystream words, one for each link direction.

The control word is `ctrl[0]` = serial load bit, `ctrl[1]` = force every generator register to shift, and `ctrl[2]` = synchronous active-high clear of the generator. The sequencer is an enumerated state machine with these states: `ST_IDLE`, `ST_CLR` (1 cycle), `ST_KEY` (64 cycles), `ST_FRAME` (22 cycles), `ST_MIX` (100 cycles), `ST_CAP_A` (114 cycles), `ST_CAP_B` (114 cycles) and `ST_DONE` (1 cycle). Its transitions are: idle to clear on `start`, and from clear through key, frame, mix, capture A, capture B and done, each on the last count of a shared phase counter. The last transition is done back to idle. The generator steps at the clock edge that ends a cycle. Each keystream bit is therefore taken one cycle later, at the edge that ends the following cycle. This is why the last bit of word A is captured during the first `ST_CAP_B` cycle and the last bit of word B during `ST_DONE`.

Top module: `ksg_frame_seq`

## Requirements
- R1: After reset `busy`, `done` and `ctrl` are 0 and both words are 0.
- R2: `start` is acted on only while `busy` is low. Key and frame number are registered at that edge, and later changes on `key` or `frame_no` have no effect on the run.
- R3: In the first cycle after an accepted start, `ctrl` is 3'b100 (clear only), for exactly one cycle.
- R4: In the next 64 cycles, `ctrl[2:1]` is 2'b01 and `ctrl[0]` is key bit i in cycle i (i = 0..63, least significant bit first).
- R5: In the next 22 cycles, `ctrl[2:1]` is 2'b01 and `ctrl[0]` is frame-number bit j in cycle j (j = 0..21, least significant bit first).
- R6: In the next 100 cycles `ctrl` is 3'b000, and the keystream bits produced by these steps reach neither word.
- R7: `word_ab` collects the 114 bits produced by the 114 generator steps after mixing. The bit after each step shifts in at bit 0, so the first bit produced ends at bit 113.
- R8: `word_ba` collects the next 114 bits in the same way.
- R9: `done` is a single-cycle pulse 416 clock edges after the start edge. `busy` is high from the cycle after start until the cycle before `done`, and it is low while `done` is high.
- R10: A `start` while `busy` is high is ignored: the schedule and the words are those of the run in progress.
- R11: While idle, both words hold their values until the next accepted start.
- R12: Outside the clear and load phases (mixing, capture, done and idle), `ctrl` is 3'b000. The force bit is never high without `busy`, and the clear bit never appears together with the force bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame sequence (honoured only when idle) |
| key | input | 64 | Session key |
| frame_no | input | 22 | Frame number |
| ks_bit | input | 1 | Keystream bit from the generator |
| ctrl | output | 3 | Generator control: [0] load data, [1] force shift, [2] clear |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when both words are valid |
| word_ab | output | 114 | First-direction keystream word |
| word_ba | output | 114 | Second-direction keystream word |

## Verification
The assertions assume that `start` can arrive at any time, including during a run, and that `key`, `frame_no` and `ks_bit` are arbitrary. They rely only on reset being applied first. The bench keeps within this by driving `start` only at falling edges. It injects spurious starts and scrambles the key and frame inputs mid-run on purpose. It feeds `ks_bit` from a behavioural generator that obeys the control word. The expected words come from a bench function that models the generator in software. A published key/frame pair with known words anchors that model and the sequencer's bit alignment.

// File: rtl/ksg_seq_pkg.sv
package ksg_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CLR, ST_KEY, ST_FRAME, ST_MIX, ST_CAP_A, ST_CAP_B, ST_DONE
    } seq_state_t;

    localparam int CTL_W     = 3;
    localparam int CTL_DATA  = 0;
    localparam int CTL_FORCE = 1;
    localparam int CTL_CLR   = 2;
endpackage

// File: rtl/ksg_phase_cnt.sv
module ksg_phase_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ksg_cap_shreg.sv
module ksg_cap_shreg #(
    parameter int W = 114
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  word <= '0;
        else if (en) word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/ksg_ctrl_mux.sv
module ksg_ctrl_mux
    import ksg_seq_pkg::*;
#(
    parameter int KEY_W  = 64,
    parameter int FN_W   = 22,
    parameter int KEY_IW = $clog2(KEY_W),
    parameter int FN_IW  = $clog2(FN_W)
) (
    input  seq_state_t        state,
    input  logic [KEY_IW-1:0] key_idx,
    input  logic [FN_IW-1:0]  fn_idx,
    input  logic [KEY_W-1:0]  key_q,
    input  logic [FN_W-1:0]   fn_q,
    output logic [CTL_W-1:0]  ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_CLR: ctrl[CTL_CLR] = 1'b1;
            ST_KEY: begin
                ctrl[CTL_FORCE] = 1'b1;
                ctrl[CTL_DATA]  = key_q[key_idx];
            end
            ST_FRAME: begin
                ctrl[CTL_FORCE] = 1'b1;
                ctrl[CTL_DATA]  = fn_q[fn_idx];
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/ksg_frame_seq.sv
module ksg_frame_seq
    import ksg_seq_pkg::*;
#(
    parameter int KEY_W  = 64,
    parameter int FN_W   = 22,
    parameter int MIX_N  = 100,
    parameter int WORD_W = 114
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEY_W-1:0]  key,
    input  logic [FN_W-1:0]   frame_no,
    input  logic              ks_bit,
    output logic [2:0]        ctrl,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] word_ab,
    output logic [WORD_W-1:0] word_ba
);
    localparam int MAX_AB = (KEY_W > FN_W) ? KEY_W : FN_W;
    localparam int MAX_CD = (MIX_N > WORD_W) ? MIX_N : WORD_W;
    localparam int MAX_N  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_N);
    localparam int KEY_IW = $clog2(KEY_W);
    localparam int FN_IW  = $clog2(FN_W);

    seq_state_t        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr;
    logic [KEY_W-1:0]  key_q;
    logic [FN_W-1:0]   fn_q;
    logic              cap_a_q, cap_b_q, done_q;
    logic [1:0]        cap_en;
    logic [WORD_W-1:0] words [2];

    function automatic logic at_last(input logic [CNT_W-1:0] c, input int n);
        return c == CNT_W'(n - 1);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)                  state_nx = ST_CLR;
            ST_CLR:                               state_nx = ST_KEY;
            ST_KEY:   if (at_last(cnt, KEY_W))    state_nx = ST_FRAME;
            ST_FRAME: if (at_last(cnt, FN_W))     state_nx = ST_MIX;
            ST_MIX:   if (at_last(cnt, MIX_N))    state_nx = ST_CAP_A;
            ST_CAP_A: if (at_last(cnt, WORD_W))   state_nx = ST_CAP_B;
            ST_CAP_B: if (at_last(cnt, WORD_W))   state_nx = ST_DONE;
            ST_DONE:                              state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    assign cnt_clr = (state_nx != state) || (state == ST_IDLE);

    ksg_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
    );

    // registered outputs and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q   <= '0;
            fn_q    <= '0;
            cap_a_q <= 1'b0;
            cap_b_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                key_q <= key;
                fn_q  <= frame_no;
            end
            cap_a_q <= (state == ST_CAP_A);
            cap_b_q <= (state == ST_CAP_B);
            done_q  <= (state == ST_DONE);
        end
    end

    ksg_ctrl_mux #(.KEY_W(KEY_W), .FN_W(FN_W)) i_mux (
        .state(state), .key_idx(cnt[KEY_IW-1:0]), .fn_idx(cnt[FN_IW-1:0]),
        .key_q(key_q), .fn_q(fn_q), .ctrl(ctrl)
    );

    assign cap_en = {cap_b_q, cap_a_q};

    for (genvar g = 0; g < 2; g++) begin : g_cap
        ksg_cap_shreg #(.W(WORD_W)) i_cap (
            .clk(clk), .rst_n(rst_n), .en(cap_en[g]), .din(ks_bit), .word(words[g])
        );
    end

    assign word_ab = words[0];
    assign word_ba = words[1];
    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
endmodule

// File: rtl/ksg_frame_seq_chk.sv
module ksg_frame_seq_chk #(
    parameter int WORD_W = 114
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        ctrl,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] word_ab,
    input logic [WORD_W-1:0] word_ba
);
    a_r3_clear_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (ctrl == 3'b100 && busy));

    a_r3_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (ctrl != 3'b100));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r11_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(word_ab) && $stable(word_ba)));

    a_r12_force_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[1] |-> busy);

    a_r12_clear_excl_force: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[2] |-> !ctrl[1] && !ctrl[0]);

    a_r4_data_with_force: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] |-> ctrl[1]);
endmodule

bind ksg_frame_seq ksg_frame_seq_chk #(.WORD_W(WORD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .busy(busy),
    .done(done), .word_ab(word_ab), .word_ba(word_ba)
);

// File: tb/test_ksg_frame_seq.sv
`timescale 1ns/1ps

module tb_ksg_core (
    input  logic       clk,
    input  logic [2:0] ctrl,
    output logic       ks
);
    logic [18:0] ra;
    logic [21:0] rb;
    logic [22:0] rc;
    logic        maj;

    initial begin ra = '0; rb = '0; rc = '0; end

    assign maj = (int'(ra[8]) + int'(rb[10]) + int'(rc[10])) >= 2;
    assign ks  = ra[18] ^ rb[21] ^ rc[22];

    always_ff @(posedge clk) begin
        if (ctrl[2]) begin
            ra <= '0; rb <= '0; rc <= '0;
        end else begin
            if (ctrl[1] || ra[8] == maj)
                ra <= {ra[17:0], ctrl[0] ^ ra[13] ^ ra[16] ^ ra[17] ^ ra[18]};
            if (ctrl[1] || rb[10] == maj)
                rb <= {rb[20:0], ctrl[0] ^ rb[20] ^ rb[21]};
            if (ctrl[1] || rc[10] == maj)
                rc <= {rc[21:0], ctrl[0] ^ rc[7] ^ rc[20] ^ rc[21] ^ rc[22]};
        end
    end
endmodule

module test_ksg_frame_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  key = '0;
    logic [21:0]  frame_no = '0;
    logic         ks_bit;
    logic [2:0]   ctrl;
    logic         busy, done;
    logic [113:0] word_ab, word_ba;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ksg_frame_seq i_ksg_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .frame_no(frame_no),
        .ks_bit(ks_bit), .ctrl(ctrl), .busy(busy), .done(done),
        .word_ab(word_ab), .word_ba(word_ba)
    );

    tb_ksg_core i_core (.clk(clk), .ctrl(ctrl), .ks(ks_bit));

    task automatic check(input bit ok, input string req, input logic [227:0] act,
                         input logic [227:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // software model of the generator over the whole schedule
    function automatic logic [227:0] ref_stream(input logic [63:0] k, input logic [21:0] f);
        logic [18:0] a = '0;
        logic [21:0] b = '0;
        logic [22:0] c = '0;
        logic [227:0] res = '0;
        for (int t = 0; t < 414; t++) begin
            logic d, frc, m, sa, sb, sc;
            d   = (t < 64) ? k[t] : (t < 86) ? f[t-64] : 1'b0;
            frc = (t < 86);
            m   = (int'(a[8]) + int'(b[10]) + int'(c[10])) >= 2;
            sa  = frc || (a[8] == m);
            sb  = frc || (b[10] == m);
            sc  = frc || (c[10] == m);
            if (sa) a = {a[17:0], d ^ a[13] ^ a[16] ^ a[17] ^ a[18]};
            if (sb) b = {b[20:0], d ^ b[20] ^ b[21]};
            if (sc) c = {c[21:0], d ^ c[7] ^ c[20] ^ c[21] ^ c[22]};
            if (t >= 186) res = {res[226:0], a[18] ^ b[21] ^ c[22]};
        end
        return res;
    endfunction

    function automatic logic [2:0] exp_ctrl(input int cyc, input logic [63:0] k,
                                            input logic [21:0] f);
        if (cyc == 1)  return 3'b100;
        if (cyc <= 65) return {2'b01, k[cyc-2]};
        if (cyc <= 87) return {2'b01, f[cyc-66]};
        return 3'b000;
    endfunction

    task automatic run(input logic [63:0] k, input logic [21:0] f, input bit spurious,
                       input string tag);
        int e_clr = 0, e_key = 0, e_fn = 0, e_mix = 0, e_rest = 0, e_busy = 0;
        logic [227:0] exp_w;
        exp_w = ref_stream(k, f);
        @(negedge clk);
        key = k; frame_no = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        key = {$urandom, $urandom};
        frame_no = 22'($urandom);
        for (int cyc = 1; cyc <= 416; cyc++) begin
            logic [2:0] ec;
            ec = exp_ctrl(cyc, k, f);
            if (ctrl != ec) begin
                if (cyc == 1)       e_clr++;
                else if (cyc <= 65) e_key++;
                else if (cyc <= 87) e_fn++;
                else if (cyc <= 187) e_mix++;
                else                e_rest++;
            end
            if (!busy || done) e_busy++;
            if (spurious && cyc == 120) begin
                start = 1'b1; key = ~k; frame_no = ~f;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(e_clr == 0, {"R3 clear cycle ", tag}, 228'(e_clr), 0);
        check(e_key == 0, {"R4 key load ", tag}, 228'(e_key), 0);
        check(e_fn == 0, {"R5 frame load ", tag}, 228'(e_fn), 0);
        check(e_mix == 0, {"R6 mix ctrl ", tag}, 228'(e_mix), 0);
        check(e_rest == 0, {"R12 capture ctrl ", tag}, 228'(e_rest), 0);
        check(e_busy == 0, {"R9 busy during run ", tag}, 228'(e_busy), 0);
        check(done && !busy, {"R9 done at edge 416 ", tag}, 228'({done, busy}), 228'(2'b10));
        check(word_ab == exp_w[227:114], {"R7 word_ab ", tag}, 228'(word_ab), 228'(exp_w[227:114]));
        check(word_ba == exp_w[113:0], {"R8 word_ba ", tag}, 228'(word_ba), 228'(exp_w[113:0]));
        if (spurious)
            check(word_ab == exp_w[227:114] && word_ba == exp_w[113:0],
                  {"R10 start while busy ignored ", tag}, 228'(word_ab), 228'(exp_w[227:114]));
        @(negedge clk);
        check(!done && ctrl == 3'b000, {"R9 done single pulse ", tag}, 228'({done, ctrl}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] kk;
        logic [21:0] ff;
        logic [113:0] hold_a, hold_b;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check(!busy && !done && ctrl == 3'b000 && word_ab == '0 && word_ba == '0,
              "R1 reset state", 228'({busy, done, ctrl}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // known-vector anchor for the bench model
        kk = 64'hEFCDAB8967452312;
        ff = 22'h000134;
        check(ref_stream(kk, ff) == {114'h14D3AA960BFA0546ADB861569CA30,
                                     114'h093F4D68D757ED949B4CBE41B7C6B},
              "R7 R8 bench model anchor", ref_stream(kk, ff), 0);
        run(kk, ff, 1'b0, "known");
        check(word_ab == 114'h14D3AA960BFA0546ADB861569CA30, "R7 known word_ab",
              228'(word_ab), 228'(114'h14D3AA960BFA0546ADB861569CA30));

        // R11: hold while idle with inputs wiggling
        hold_a = word_ab; hold_b = word_ba;
        repeat (5 + ($urandom % 20)) begin
            key = {$urandom, $urandom}; frame_no = 22'($urandom);
            @(negedge clk);
        end
        check(word_ab == hold_a && word_ba == hold_b, "R11 words hold while idle",
              228'(word_ab), 228'(hold_a));

        // corner keys
        run('0, '0, 1'b0, "zero");
        run('1, 22'h3FFFFF, 1'b0, "ones");
        run(64'h1, 22'h200000, 1'b1, "edge bits R2 R10");

        for (int r = 0; r < 4; r++) begin
            kk = {$urandom, $urandom};
            ff = 22'($urandom);
            run(kk, ff, (r % 2) == 1, "random");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule